// File: doc/BRIEF.md
# Quadrature Downconverter with Rate-125 Decimation

The block turns a stream of real converter samples into baseband data at a much lower rate. The converter delivers 32 million samples per second. Each sample is multiplied by the cosine and the sine of a numerically controlled oscillator, which gives an in-phase (I) branch and a quadrature (Q) branch. Each branch then goes through a three-stage cascaded integrator-comb low-pass filter that keeps one result for every 125 inputs. The resulting 16-bit words go to a USB FIFO.

A small write-only register port sets two values. The first is the 32-bit oscillator tuning word, so the phase step per sample is the tuning word divided by 2^32 of a full turn. The second is the output mode. A single-channel mode sends one chosen branch. A complex mode sends interleaved I/Q words. Retuning never clears the oscillator phase, so a retuned stream stays phase-continuous.

Top module: `ddc_top`

## Requirements
- R1: The oscillator phase is a 32-bit accumulator that starts at 0 after reset. Sample n of the accepted stream is mixed at phase p(n). After that sample, the phase becomes p(n) plus the tuning word, modulo 2^32.
- R2: The top 10 bits of the phase form an index k. The I branch uses 32767*cos(2*pi*(k+0.5)/1024) and the Q branch uses 32767*sin(2*pi*(k+0.5)/1024), each within 0.2 % of full scale. Each mixer result is floor(sample*amplitude/4096).
- R3: Each branch is the three-fold cascade of 125-sample running sums of its mixer results. A result is taken after every 125th accepted sample since reset, and is the cascade value divided by 2^21 and rounded down to 16 bits. No result appears before 125 samples have been accepted.
- R4: When mode bit0 is 0 (single channel), one word is sent per result. Mode bit1 chooses the branch: 0 sends I, 1 sends Q. out_is_q is 1 exactly for a Q word.
- R5: When mode bit0 is 1 (complex), each result gives two words on consecutive cycles: the I word with out_is_q=0, then the Q word with out_is_q=1.
- R6: out_valid is high for exactly one cycle per word. Without accepted samples, no word is sent.
- R7: A write with cfg_sel=0 loads cfg_wdata as the tuning word. The new word sets the phase step for every sample accepted after the write, and the phase that has already accumulated is kept.
- R8: After reset, the tuning word is 0, the mode is single-channel I, all filter state is zero, and out_valid is low.
- R9: Cycles with in_valid low do not change the oscillator, the filters or the output. Only accepted samples count.
- R10: A write with cfg_sel=1 loads cfg_wdata[1:0] as the mode. The mode in force when a result leaves the filter decides how that result is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A converter sample is presented this cycle |
| in_sample | input | 12 | Signed converter sample |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 tuning word, 1 mode |
| cfg_wdata | input | 32 | Register write data |
| out_valid | output | 1 | One-cycle strobe per output word |
| out_data | output | 16 | Signed output word |
| out_is_q | output | 1 | 1 when the word belongs to the Q branch |

## Verification
The bench first drives a tone at the oscillator frequency. A wrong quadrant fold or swapped sine and cosine would then move energy between I and Q by thousands of counts. The tuning word is changed in the middle of the stream, so a design that reset the phase would rotate every later result. A run of 124 samples followed by one more tests the decimation boundary: an off-by-one ratio sends a word early, or sends the wrong number of words. Idle gaps, full-scale constants and switching between I-only, Q-only and complex modes show whether the design miscounts idle cycles, overflows the filter, or swaps the order of a pair or its flag.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    localparam int IN_W    = 12;
    localparam int PHASE_W = 32;
    localparam int LUT_AW  = 8;
    localparam int AMP_W   = 16;
    localparam int MIX_W   = 16;
    localparam int DECIM   = 125;
    localparam int STAGES  = 3;
    localparam int OUT_W   = 16;

    localparam int IDX_W     = LUT_AW + 2;
    localparam int LUT_N     = 1 << LUT_AW;
    localparam int GROWTH    = $clog2(DECIM ** STAGES);
    localparam int ACC_W     = MIX_W + GROWTH;
    localparam int PROD_W    = IN_W + AMP_W;
    localparam int CNT_W     = $clog2(DECIM);
    localparam int AMP_MAX   = (1 << (AMP_W - 1)) - 1;
    localparam int ROM_BITS  = LUT_N * AMP_W;

    typedef logic signed [IN_W-1:0]  sample_t;
    typedef logic signed [AMP_W-1:0] amp_t;
    typedef logic signed [MIX_W-1:0] mix_t;
    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic signed [OUT_W-1:0] out_t;
    typedef logic [PHASE_W-1:0]      phase_t;
    typedef logic [IDX_W-1:0]        idx_t;

    typedef enum logic {CFG_TUNE = 1'b0, CFG_MODE = 1'b1} cfg_sel_e;

    typedef struct packed {
        logic q_sel;
        logic cplx;
    } mode_t;

    typedef struct packed {
        amp_t cos_v;
        amp_t sin_v;
    } trig_t;

    typedef struct packed {
        mix_t i;
        mix_t q;
    } mix_pair_t;

    typedef struct packed {
        out_t i;
        out_t q;
    } out_pair_t;

    // Rational quarter-wave sine sampled at the centre of each table cell.
    function automatic amp_t quarter_sine(int k);
        longint h, t, num, den;
        h   = 4 * LUT_N;
        t   = 2 * k + 1;
        num = longint'(AMP_MAX) * 16 * t * (h - t);
        den = 5 * h * h - 4 * t * (h - t);
        return amp_t'(num / den);
    endfunction

    function automatic logic [ROM_BITS-1:0] build_rom();
        logic [ROM_BITS-1:0] r;
        r = '0;
        for (int k = 0; k < LUT_N; k++) begin
            r[k*AMP_W +: AMP_W] = quarter_sine(k);
        end
        return r;
    endfunction

endpackage

// File: rtl/ddc_nco.sv
module ddc_nco
    import ddc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adv,
    input  phase_t step,
    output trig_t  trig
);

    localparam logic [ROM_BITS-1:0] ROM = build_rom();

    phase_t phase_q;
    idx_t   idx_q;

    function automatic amp_t rom_at(logic [LUT_AW-1:0] k);
        return amp_t'(ROM[k*AMP_W +: AMP_W]);
    endfunction

    function automatic amp_t sine_of(idx_t idx);
        logic [1:0]        quad;
        logic [LUT_AW-1:0] k;
        amp_t              m;
        quad = idx[IDX_W-1 -: 2];
        k    = idx[LUT_AW-1:0];
        m    = quad[0] ? rom_at(~k) : rom_at(k);
        return quad[1] ? -m : m;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            idx_q   <= '0;
        end else if (adv) begin
            idx_q   <= phase_q[PHASE_W-1 -: IDX_W];
            phase_q <= phase_q + step;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig <= '0;
        end else begin
            trig.sin_v <= sine_of(idx_q);
            trig.cos_v <= sine_of(idx_q + idx_t'(LUT_N));
        end
    end

endmodule

// File: rtl/ddc_mixer.sv
module ddc_mixer
    import ddc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_v,
    input  sample_t   x,
    input  trig_t     trig,
    output logic      out_v,
    output mix_pair_t mix
);

    logic signed [PROD_W-1:0] prod_i, prod_q;

    always_comb begin
        prod_i = PROD_W'(x) * PROD_W'(trig.cos_v);
        prod_q = PROD_W'(x) * PROD_W'(trig.sin_v);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_v <= 1'b0;
            mix   <= '0;
        end else begin
            out_v <= in_v;
            if (in_v) begin
                mix.i <= prod_i[PROD_W-1 -: MIX_W];
                mix.q <= prod_q[PROD_W-1 -: MIX_W];
            end
        end
    end

endmodule

// File: rtl/ddc_cic.sv
module ddc_cic
    import ddc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_v,
    input  logic tick,
    input  mix_t din,
    output logic dout_v,
    output out_t dout
);

    acc_t integ    [STAGES];
    acc_t integ_nx [STAGES];
    acc_t dly      [STAGES];
    acc_t cmb      [STAGES];

    always_comb begin
        integ_nx[0] = integ[0] + ACC_W'(din);
        for (int s = 1; s < STAGES; s++) begin
            integ_nx[s] = integ[s] + integ_nx[s-1];
        end
        cmb[0] = integ_nx[STAGES-1] - dly[0];
        for (int s = 1; s < STAGES; s++) begin
            cmb[s] = cmb[s-1] - dly[s];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                integ[s] <= '0;
                dly[s]   <= '0;
            end
            dout_v <= 1'b0;
            dout   <= '0;
        end else begin
            dout_v <= tick;
            if (in_v) begin
                for (int s = 0; s < STAGES; s++) begin
                    integ[s] <= integ_nx[s];
                end
            end
            if (tick) begin
                dly[0] <= integ_nx[STAGES-1];
                for (int s = 1; s < STAGES; s++) begin
                    dly[s] <= cmb[s-1];
                end
                dout <= cmb[STAGES-1][ACC_W-1 -: OUT_W];
            end
        end
    end

endmodule

// File: rtl/ddc_out.sv
module ddc_out
    import ddc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pair_v,
    input  out_pair_t pair,
    input  mode_t     mode,
    output logic      out_valid,
    output out_t      out_data,
    output logic      out_is_q
);

    typedef enum logic {ST_IDLE, ST_SEND_Q} ost_e;

    ost_e state;
    out_t hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            hold_q    <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_is_q  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (pair_v) begin
                        out_valid <= 1'b1;
                        hold_q    <= pair.q;
                        if (mode.cplx) begin
                            out_data <= pair.i;
                            out_is_q <= 1'b0;
                            state    <= ST_SEND_Q;
                        end else begin
                            out_data <= mode.q_sel ? pair.q : pair.i;
                            out_is_q <= mode.q_sel;
                        end
                    end
                end
                ST_SEND_Q: begin
                    out_valid <= 1'b1;
                    out_data  <= hold_q;
                    out_is_q  <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ddc_top.sv
module ddc_top
    import ddc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [IN_W-1:0]    in_sample,
    input  logic               cfg_wr,
    input  logic               cfg_sel,
    input  logic [PHASE_W-1:0] cfg_wdata,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_data,
    output logic               out_is_q
);

    phase_t    tune_q;
    mode_t     mode_q;
    sample_t   x_a, x_b;
    logic      va, vb, vc;
    trig_t     trig;
    mix_pair_t mix;
    logic [CNT_W-1:0] dec_cnt;
    logic      tick;
    mix_t      br_in  [2];
    out_t      br_out [2];
    logic      br_v   [2];
    out_pair_t pair;
    out_t      word;

    always_ff @(posedge clk) begin
        if (rst) begin
            tune_q <= '0;
            mode_q <= '0;
        end else if (cfg_wr) begin
            if (cfg_sel == CFG_TUNE) tune_q <= cfg_wdata;
            else                     mode_q <= mode_t'(cfg_wdata[1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            va  <= 1'b0;
            vb  <= 1'b0;
            x_a <= '0;
            x_b <= '0;
        end else begin
            va <= in_valid;
            vb <= va;
            if (in_valid) x_a <= sample_t'(in_sample);
            x_b <= x_a;
        end
    end

    ddc_nco u_nco (
        .clk  (clk),
        .rst  (rst),
        .adv  (in_valid),
        .step (tune_q),
        .trig (trig)
    );

    ddc_mixer u_mix (
        .clk   (clk),
        .rst   (rst),
        .in_v  (vb),
        .x     (x_b),
        .trig  (trig),
        .out_v (vc),
        .mix   (mix)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_cnt <= '0;
        end else if (vc) begin
            dec_cnt <= (dec_cnt == CNT_W'(DECIM - 1)) ? '0 : dec_cnt + 1'b1;
        end
    end

    assign tick     = vc && (dec_cnt == CNT_W'(DECIM - 1));
    assign br_in[0] = mix.i;
    assign br_in[1] = mix.q;

    for (genvar b = 0; b < 2; b++) begin : g_branch
        ddc_cic u_cic (
            .clk    (clk),
            .rst    (rst),
            .in_v   (vc),
            .tick   (tick),
            .din    (br_in[b]),
            .dout_v (br_v[b]),
            .dout   (br_out[b])
        );
    end

    assign pair.i = br_out[0];
    assign pair.q = br_out[1];

    ddc_out u_out (
        .clk       (clk),
        .rst       (rst),
        .pair_v    (br_v[0]),
        .pair      (pair),
        .mode      (mode_q),
        .out_valid (out_valid),
        .out_data  (word),
        .out_is_q  (out_is_q)
    );

    assign out_data = word;

endmodule

// File: rtl/ddc_checker.sv
module ddc_checker
    import ddc_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic out_valid,
    input logic out_is_q,
    input logic mode_cplx
);

    logic        prev_v, prev_q;
    logic [39:0] n_in, n_grp;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_v <= 1'b0;
            prev_q <= 1'b0;
            n_in   <= '0;
            n_grp  <= '0;
        end else begin
            prev_v <= out_valid;
            prev_q <= out_is_q;
            if (in_valid) n_in <= n_in + 40'd1;
            if (out_valid && !(prev_v && out_is_q)) n_grp <= n_grp + 40'd1;
        end
    end

    // R3: never more results than completed groups of DECIM samples
    p_rate_r3: assert property (@(posedge clk) disable iff (rst)
        (n_grp * 40'(DECIM)) <= n_in);

    // R4: a single-channel word stands alone
    p_single_word_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !mode_cplx && !prev_v) |=> !out_valid);

    // R5: an I word in complex mode is followed at once by its Q word
    p_q_follows_i_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_q && mode_cplx) |=> (out_valid && out_is_q));

    // R6: two back-to-back words are always I then Q, never three in a row
    p_pair_order_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && prev_v) |-> (out_is_q && !prev_q));

    // R8: reset silences the output
    p_reset_quiet_r8: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

bind ddc_top ddc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_is_q  (out_is_q),
    .mode_cplx (mode_q.cplx)
);

// File: tb/sim_ddc_top.sv
`timescale 1ns/1ps
module sim_ddc_top;

    localparam real PI  = 3.14159265358979;
    localparam real TOL = 40.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] in_sample = '0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_is_q;

    ddc_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .out_valid(out_valid), .out_data(out_data), .out_is_q(out_is_q)
    );

    always #5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    longint cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    int     got_v[$];
    bit     got_q[$];
    longint got_t[$];
    real    exp_v[$];
    bit     exp_q[$];
    bit     exp_second[$];

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            got_v.push_back(int'($signed(out_data)));
            got_q.push_back(out_is_q);
            got_t.push_back(cyc);
        end
    end

    // bench model state
    logic [31:0] m_phase = '0;
    logic [31:0] m_tw = '0;
    bit  m_cplx = 1'b0, m_qsel = 1'b0;
    int  m_cnt = 0, m_pos = 0;
    real hb [2][3][125];
    real sm [2][3];
    longint n_glob = 0;

    task automatic check(bit ok, string req, string what, real act, real expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, expv);
        end
    endtask

    task automatic model_sample(int x);
        int  idx;
        real ang, mv[2], v;
        idx   = int'(m_phase[31:22]);
        ang   = 2.0 * PI * (real'(idx) + 0.5) / 1024.0;
        mv[0] = real'(x) * 32767.0 * $cos(ang) / 4096.0;
        mv[1] = real'(x) * 32767.0 * $sin(ang) / 4096.0;
        for (int b = 0; b < 2; b++) begin
            v = mv[b];
            for (int s = 0; s < 3; s++) begin
                sm[b][s] = sm[b][s] + v - hb[b][s][m_pos];
                hb[b][s][m_pos] = v;
                v = sm[b][s];
            end
        end
        m_pos   = (m_pos + 1) % 125;
        m_phase = m_phase + m_tw;
        m_cnt++;
        if (m_cnt == 125) begin
            m_cnt = 0;
            if (m_cplx) begin
                exp_v.push_back(sm[0][2] / 2097152.0); exp_q.push_back(1'b0); exp_second.push_back(1'b0);
                exp_v.push_back(sm[1][2] / 2097152.0); exp_q.push_back(1'b1); exp_second.push_back(1'b1);
            end else begin
                exp_v.push_back(sm[m_qsel ? 1 : 0][2] / 2097152.0);
                exp_q.push_back(m_qsel);
                exp_second.push_back(1'b0);
            end
        end
    endtask

    task automatic send(int x);
        int c;
        c = x;
        if (c > 2047) c = 2047;
        if (c < -2048) c = -2048;
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = 12'(c);
        model_sample(c);
        n_glob++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_run(int n, real amp, real fr, real dc, int gap_max);
        int x;
        for (int i = 0; i < n; i++) begin
            x = int'(dc + amp * $cos(2.0 * PI * fr * real'(n_glob)))
                + int'($urandom_range(32)) - 16;
            send(x);
            if (gap_max > 0) repeat (int'($urandom_range(gap_max))) @(negedge clk);
        end
    endtask

    task automatic write_cfg(bit sel, logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (sel) begin m_cplx = d[0]; m_qsel = d[1]; end
        else m_tw = d;
    endtask

    task automatic compare(string req);
        int n;
        repeat (20) @(negedge clk);
        check(got_v.size() == exp_v.size(), req, "word count",
              real'(got_v.size()), real'(exp_v.size()));
        n = (got_v.size() < exp_v.size()) ? got_v.size() : exp_v.size();
        for (int i = 0; i < n; i++) begin
            check(got_q[i] == exp_q[i], req, "out_is_q", real'(got_q[i]), real'(exp_q[i]));
            check((real'(got_v[i]) - exp_v[i] <= TOL) && (exp_v[i] - real'(got_v[i]) <= TOL),
                  req, "word value", real'(got_v[i]), exp_v[i]);
            if (exp_second[i] && i > 0)
                check(got_t[i] - got_t[i-1] == 1, "R5", "pair spacing",
                      real'(got_t[i] - got_t[i-1]), 1.0);
        end
        got_v.delete(); got_q.delete(); got_t.delete();
        exp_v.delete(); exp_q.delete(); exp_second.delete();
    endtask

    function automatic logic [31:0] tw_of(real fr);
        return 32'(longint'(fr * 4294967296.0));
    endfunction

    initial begin
        void'($urandom(32'd4242));
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < 3; s++) begin
                sm[b][s] = 0.0;
                for (int k = 0; k < 125; k++) hb[b][s][k] = 0.0;
            end
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R8: quiet after reset, defaults in force
        for (int i = 0; i < 4; i++) begin
            repeat (5) @(negedge clk);
            check(out_valid == 1'b0, "R8", "out_valid after reset", real'(out_valid), 0.0);
        end

        // R1 R2 R3 R8: tuning 0, single I by default, constant input
        send_run(375, 0.0, 0.0, 1000.0, 0);
        compare("R3");

        // R3 R6: 124 samples give no word, the 125th gives one
        send_run(124, 0.0, 0.0, -700.0, 0);
        repeat (20) @(negedge clk);
        check(got_v.size() == 0, "R3", "word before 125 samples", real'(got_v.size()), 0.0);
        send_run(1, 0.0, 0.0, -700.0, 0);
        compare("R6");

        // R6 R9: idle input yields no word
        repeat (300) @(negedge clk);
        check(got_v.size() == 0, "R9", "words while idle", real'(got_v.size()), 0.0);

        // R5 R10 R2: complex mode, tone at the oscillator frequency
        write_cfg(1'b1, 32'd1);
        write_cfg(1'b0, tw_of(0.05));
        send_run(500, 1500.0, 0.05, 0.0, 0);
        compare("R5");

        // R4 R10: single Q
        write_cfg(1'b1, 32'd2);
        send_run(250, 1500.0, 0.05, 0.0, 0);
        compare("R4");

        // R7: retune mid-stream, phase continues
        write_cfg(1'b1, 32'd1);
        write_cfg(1'b0, tw_of(0.0625));
        send_run(250, 1500.0, 0.05, 0.0, 0);
        write_cfg(1'b0, tw_of(0.047));
        send_run(375, 1500.0, 0.05, 0.0, 0);
        compare("R7");

        // R9: random idle gaps inside the stream
        send_run(375, 1200.0, 0.05, 0.0, 3);
        compare("R9");

        // R3: full-scale constants, no overflow
        write_cfg(1'b0, 32'd0);
        send_run(500, 0.0, 0.0, -2100.0, 0);
        compare("R3");
        send_run(500, 0.0, 0.0, 2100.0, 0);
        compare("R3");

        // R1 R2: random tuning word and random samples, single I
        write_cfg(1'b1, 32'd0);
        write_cfg(1'b0, $urandom());
        send_run(500, 1800.0, 0.011, 0.0, 0);
        compare("R1");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule